// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

The controller gathers up to 32 interrupt sources into one request toward a processor core. Source 0 has the highest priority and source 31 the lowest. Requests land in a latch register. A latched source competes for service only when its bit in the software mask register is set and the global enable input is high. The winning source is shown as an index and as a vector address. Each vector occupies eight instruction words, so the address is a base plus eight times the index. A few sources come from external pins, and those pass through a two-flop synchronizer and a rising-edge detector.

When the core accepts the request, the source moves from the latch into an in-service register. It cannot be latched again until a return-from-interrupt strobe retires it. A nesting input picks one of two policies while anything is in service: block every source, or let through only sources of strictly higher priority than the most urgent routine in service. For a configurable set of sources, the controller signals a status push toward a status stack when the source is taken, and a matching pop when that source is retired. Software can write the mask register, and it can discard pending requests by writing ones to the latch register.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, irq_o, push_o and pop_o are low and the mask register is all zeros, so no latched source is presented until software writes the mask.
- R2: A latched source is presented only when its mask bit is 1 and glb_en_i is 1; with glb_en_i low, irq_o is low.
- R3: Among eligible latched sources the lowest index wins; src_o is that index and vec_o equals VEC_BASE (default 0x000100) plus 8 times src_o.
- R4: In a cycle with irq_o and ack_i both high the winner is taken: its latch bit clears and its in-service bit sets at the next edge, and requests for that source are ignored while its in-service bit is set.
- R5: With nest_mode_i = 0 and any source in service, irq_o stays low.
- R6: With nest_mode_i = 1 and sources in service, only sources whose index is strictly below the lowest in-service index may be presented.
- R7: rti_i clears the lowest-index in-service bit at the next edge; rti_i with nothing in service changes nothing and gives no pop_o.
- R8: push_o is high in a take cycle whose winner has its PUSH_MASK bit set (default 0x00000702: sources 1, 8, 9, 10); pop_o is high in an rti_i cycle whose retired source has its PUSH_MASK bit set.
- R9: External pin k (default 3 pins) maps to source EXT_LSB+k (default 8+k); a rising edge latches it after the two-flop synchronizer, and a pin held high latches it only once.
- R10: With sw_we_i high, sw_sel_i = 0 loads the mask from sw_wdata_i and sw_sel_i = 1 clears every latched bit written as 1; a request that arrives in the same cycle as such a clear leaves that bit set.
- R11: A take and an rti_i in the same cycle both apply: the old lowest in-service bit clears and the new winner's bit sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| int_req_i | input | NUM_SRC | Internal request per source, sampled each cycle |
| ext_irq_i | input | NUM_EXT | Asynchronous external request pins |
| sw_we_i | input | 1 | Software register write strobe |
| sw_sel_i | input | 1 | Write target: 0 mask load, 1 latch clear |
| sw_wdata_i | input | NUM_SRC | Software write data |
| glb_en_i | input | 1 | Global interrupt enable |
| nest_mode_i | input | 1 | 0 blocks all while in service, 1 allows higher priority only |
| ack_i | input | 1 | Core accepts the presented interrupt |
| rti_i | input | 1 | Return-from-interrupt strobe |
| irq_o | output | 1 | Interrupt presented |
| src_o | output | SRC_W | Index of the winning source |
| vec_o | output | ADDR_W | Vector address of the winning source |
| push_o | output | 1 | Status push for the taken source |
| pop_o | output | 1 | Status pop for the retired source |

## Verification
Two collisions matter here: a software latch clear that lands in the same cycle as a fresh request for that bit, and a take of a higher-priority source in the same cycle as a return from the routine in service. Directed steps drive each pair in one cycle. Constrained random traffic then mixes requests, acknowledges, returns and clears so that both collisions recur with many other bits set. A bench model that steps the latch, mask and in-service state from the requirements judges every cycle by comparing irq_o, src_o, vec_o, push_o and pop_o.

// File: rtl/irq_pkg.sv
package irq_pkg;
  parameter int IRQ_NUM_SRC    = 32;
  parameter int IRQ_VEC_SHIFT  = 3;  // eight words per vector

  typedef enum logic {
    SEL_MASK = 1'b0,
    SEL_CLR  = 1'b1
  } sw_sel_e;
endpackage

// File: rtl/irq_ext_sync.sv
module irq_ext_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~s3_q;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N = 32,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] req_i,
  output logic         valid_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        valid_o = 1'b1;
        idx_o   = W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int                 NUM_SRC   = IRQ_NUM_SRC,
  parameter int                 NUM_EXT   = 3,
  parameter int                 EXT_LSB   = 8,
  parameter int                 ADDR_W    = 24,
  parameter logic [ADDR_W-1:0]  VEC_BASE  = 24'h000100,
  parameter logic [NUM_SRC-1:0] PUSH_MASK = 32'h0000_0702,
  localparam int                SRC_W     = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] int_req_i,
  input  logic [NUM_EXT-1:0] ext_irq_i,
  input  logic               sw_we_i,
  input  logic               sw_sel_i,
  input  logic [NUM_SRC-1:0] sw_wdata_i,
  input  logic               glb_en_i,
  input  logic               nest_mode_i,
  input  logic               ack_i,
  input  logic               rti_i,
  output logic               irq_o,
  output logic [SRC_W-1:0]   src_o,
  output logic [ADDR_W-1:0]  vec_o,
  output logic               push_o,
  output logic               pop_o
);
  logic [NUM_SRC-1:0] latch_q, mask_q, isr_q;
  logic [NUM_SRC-1:0] latch_d, mask_d, isr_d;
  logic [NUM_SRC-1:0] req_vec, nest_allow, eligible;
  logic [NUM_SRC-1:0] win_oh, top_oh;
  logic [NUM_EXT-1:0] ext_rise;
  logic [SRC_W-1:0]   top_idx;
  logic               isr_any, take;

  // external pins: sync + edge detect
  for (genvar k = 0; k < NUM_EXT; k++) begin : g_ext
    irq_ext_sync i_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (ext_irq_i[k]),
      .rise_o (ext_rise[k])
    );
  end

  always_comb begin
    req_vec = int_req_i;
    for (int k = 0; k < NUM_EXT; k++) req_vec[EXT_LSB+k] = req_vec[EXT_LSB+k] | ext_rise[k];
  end

  // most urgent routine in service
  irq_prio_enc #(.N(NUM_SRC), .W(SRC_W)) i_top_enc (
    .req_i   (isr_q),
    .valid_o (isr_any),
    .idx_o   (top_idx)
  );

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++)
      nest_allow[i] = !isr_any || (nest_mode_i && (SRC_W'(i) < top_idx));
  end

  assign eligible = latch_q & mask_q & {NUM_SRC{glb_en_i}} & nest_allow;

  irq_prio_enc #(.N(NUM_SRC), .W(SRC_W)) i_win_enc (
    .req_i   (eligible),
    .valid_o (irq_o),
    .idx_o   (src_o)
  );

  assign vec_o  = VEC_BASE + (ADDR_W'(src_o) << IRQ_VEC_SHIFT);
  assign take   = irq_o & ack_i;
  assign win_oh = take ? (NUM_SRC'(1) << src_o) : '0;
  assign top_oh = (rti_i && isr_any) ? (NUM_SRC'(1) << top_idx) : '0;
  assign push_o = take & PUSH_MASK[src_o];
  assign pop_o  = rti_i & isr_any & PUSH_MASK[top_idx];

  always_comb begin
    latch_d = latch_q & ~win_oh;
    if (sw_we_i && (sw_sel_i == SEL_CLR)) latch_d = latch_d & ~sw_wdata_i;
    // in-service sources cannot re-latch; a fresh request beats a clear
    latch_d = latch_d | (req_vec & ~isr_q & ~win_oh);
    mask_d  = (sw_we_i && (sw_sel_i == SEL_MASK)) ? sw_wdata_i : mask_q;
    isr_d   = (isr_q & ~top_oh) | win_oh;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '0;
      mask_q  <= '0;
      isr_q   <= '0;
    end else begin
      latch_q <= latch_d;
      mask_q  <= mask_d;
      isr_q   <= isr_d;
    end
  end

  AST_GATED_BY_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni) irq_o |-> (mask_q[src_o] && glb_en_i)); // R2
  AST_TAKE_ENTERS_ISR: assert property (@(posedge clk_i) disable iff (!rst_ni) take |=> isr_q[$past(src_o)]); // R4
  AST_NO_RELATCH: assert property (@(posedge clk_i) disable iff (!rst_ni) irq_o |-> !isr_q[src_o]); // R4
  AST_MASK_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni) (!nest_mode_i && isr_any) |-> !irq_o); // R5
  AST_NEST_HIGHER: assert property (@(posedge clk_i) disable iff (!rst_ni) (isr_any && irq_o) |-> (src_o < top_idx)); // R6
  AST_RTI_RETIRES: assert property (@(posedge clk_i) disable iff (!rst_ni) (rti_i && isr_any && !take) |=> ($countones(isr_q) == $countones($past(isr_q)) - 1)); // R7
  AST_PUSH_ON_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni) push_o |-> take); // R8
endmodule

// File: tb/test_irq_ctrl.sv
module test_irq_ctrl;
  localparam logic [31:0] PUSHM = 32'h0000_0702;
  localparam logic [23:0] VBASE = 24'h000100;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] int_req = '0;
  logic [2:0]  ext_irq = '0;
  logic        sw_we = 1'b0, sw_sel = 1'b0;
  logic [31:0] sw_wdata = '0;
  logic        glb_en = 1'b0, nest_mode = 1'b0, ack = 1'b0, rti = 1'b0;
  logic        irq;
  logic [4:0]  src;
  logic [23:0] vec;
  logic        push, pop;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] m_latch = '0, m_mask = '0, m_isr = '0;
  logic [2:0]  m_s1 = '0, m_s2 = '0, m_s3 = '0;

  always #2 clk = ~clk;

  irq_ctrl i_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .int_req_i(int_req), .ext_irq_i(ext_irq),
    .sw_we_i(sw_we), .sw_sel_i(sw_sel), .sw_wdata_i(sw_wdata),
    .glb_en_i(glb_en), .nest_mode_i(nest_mode), .ack_i(ack), .rti_i(rti),
    .irq_o(irq), .src_o(src), .vec_o(vec), .push_o(push), .pop_o(pop)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int first1(input logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic idle();
    int_req = '0; sw_we = 1'b0; ack = 1'b0; rti = 1'b0;
  endtask

  // inputs are set just after a falling edge; compare, step model at rising edge
  task automatic cycle(input string tag);
    int top, w;
    logic [31:0] elig, winoh, topoh, reqv;
    logic [2:0] rise;
    logic exp_irq;
    #1;
    top = first1(m_isr);
    for (int i = 0; i < 32; i++)
      elig[i] = m_latch[i] & m_mask[i] & glb_en & ((top < 0) || (nest_mode && i < top));
    w = first1(elig);
    exp_irq = (w >= 0);
    check(tag, "irq_o", 32'(irq), 32'(exp_irq));
    if (exp_irq) begin
      check(tag, "src_o", 32'(src), w);
      check(tag, "vec_o", 32'(vec), 32'(VBASE) + 32'(8 * w));
    end
    check(tag, "push_o", 32'(push), 32'(exp_irq && ack && PUSHM[w & 31]));
    check(tag, "pop_o", 32'(pop), 32'(rti && (top >= 0) && PUSHM[top & 31]));
    @(posedge clk);
    rise = m_s2 & ~m_s3;
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_irq;
    reqv = int_req | (32'(rise) << 8);
    winoh = (exp_irq && ack) ? (32'd1 << w) : '0;
    topoh = (rti && top >= 0) ? (32'd1 << top) : '0;
    m_latch = m_latch & ~winoh;
    if (sw_we && sw_sel) m_latch = m_latch & ~sw_wdata;
    m_latch = m_latch | (reqv & ~m_isr & ~winoh);
    if (sw_we && !sw_sel) m_mask = sw_wdata;
    m_isr = (m_isr & ~topoh) | winoh;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    #1;
    check("R1", "irq_o in reset", 32'(irq), 0);
    check("R1", "push_o in reset", 32'(push), 0);
    check("R1", "pop_o in reset", 32'(pop), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    idle(); glb_en = 1'b1; nest_mode = 1'b1;
    int_req = '1;               cycle("R1");
    idle();                     cycle("R1");   // all latched, mask still zero
    sw_we = 1; sw_sel = 1; sw_wdata = '1; cycle("R10");
    idle(); sw_we = 1; sw_sel = 0; sw_wdata = '1; cycle("R2");
    idle();                     cycle("R10");  // cleared: nothing pending
    int_req = (32'd1 << 5) | (32'd1 << 9); cycle("R3");
    idle(); #1;
    check("R3", "vec_o literal", 32'(vec), 32'h128);
    cycle("R3");
    glb_en = 0;                 cycle("R2");
    glb_en = 1; sw_we = 1; sw_sel = 0; sw_wdata = ~(32'd1 << 5); cycle("R2");
    idle();                     cycle("R2");
    ack = 1;                    cycle("R8");   // take 9, push
    idle(); nest_mode = 0; int_req = (32'd1 << 9) | 32'd1; cycle("R4");
    idle();                     cycle("R5");
    nest_mode = 1;              cycle("R6");
    rti = 1;                    cycle("R8");   // retire 9, pop
    idle();                     cycle("R4");
    ack = 1;                    cycle("R4");   // take 0
    idle(); int_req = 32'd1 << 3; cycle("R6");
    idle();                     cycle("R6");
    rti = 1;                    cycle("R7");
    idle(); ack = 1;            cycle("R4");   // take 3
    idle(); int_req = 32'd1 << 1; cycle("R6");
    idle(); ack = 1; rti = 1;   cycle("R11");  // take 1, retire 3
    idle();                     cycle("R11");
    rti = 1;                    cycle("R11");
    idle(); rti = 1;            cycle("R7");   // empty in-service
    idle(); int_req = 32'd1 << 7; sw_we = 1; sw_sel = 1; sw_wdata = 32'd1 << 7; cycle("R10");
    idle();                     cycle("R10");
    sw_we = 1; sw_sel = 1; sw_wdata = 32'd1 << 7; cycle("R10");
    idle();                     cycle("R10");
    ext_irq = 3'b010;
    for (int i = 0; i < 5; i++) cycle("R9");
    ack = 1;                    cycle("R9");
    idle(); rti = 1;            cycle("R9");
    idle();
    for (int i = 0; i < 4; i++) cycle("R9");
    ext_irq = '0;
    for (int i = 0; i < 3000; i++) begin
      int_req = $urandom & $urandom & $urandom & $urandom;
      ack = ($urandom % 2) == 0;
      rti = ($urandom % 4) == 0;
      sw_we = ($urandom % 10) == 0;
      sw_sel = $urandom % 2;
      sw_wdata = sw_sel ? ($urandom & $urandom) : ($urandom | $urandom);
      glb_en = ($urandom % 10) != 0;
      if (($urandom % 16) == 0) nest_mode = ~nest_mode;
      if (($urandom % 8) == 0) ext_irq = 3'($urandom);
      cycle("R3");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule